// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the on-chip end of a four-wire serial test port. A sixteen-state controller advances on each rising edge of the test clock and chooses its next state from the mode-select line only. Through it, a tester moves an 8-bit instruction in and makes it current. It can then shift a selected data register: a one-bit pass-through stage, a 32-bit identification word, a 32-bit user word, or an external boundary chain.

The current instruction is decoded into three things. The first is a data-register select. The second is a test-mode flag that hands the pins to the boundary cells. The third is a global output-disable that floats every functional output while the scan path runs through the one-bit stage. A neighbouring device on the same board can be parked in this floating state by a short serial sequence. The only reset the port has comes from holding the mode-select line high. A power-on clear input puts the port in the same reset state when the chip powers up.

Top module: `tap_port`

## Requirements
- R1: The controller has sixteen states. It moves between them only on rising `tck` edges, and `tms` alone chooses the branch. The DR column is entered from Select-DR with `tms`=0, the IR column from Select-IR with `tms`=0, and Run-Test/Idle is left with `tms`=1.
- R2: Five rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset from any state. Four such edges starting from Shift-DR do not.
- R3: When `por_n` is low, and whenever the controller is in Test-Logic-Reset, the current instruction is IDCODE (11111110), `pins_disable` is 0 and `tdo_en` is 0.
- R4: Capture-IR loads 00000001 into the instruction shift stage. Bits leave on `tdo` least significant first, and bits from `tdi` enter at the most significant end.
- R5: A new instruction becomes current only on the falling edge of `tck` in Update-IR. Shifting or pausing in the IR column leaves the decoded outputs unchanged.
- R6: HIGHZ (11111100) drives `pins_disable` to 1, sets `bsr_test_mode` to 0, and routes the data path through the one-bit pass-through stage.
- R7: Decode: EXTEST (00000000) and INTEST (00000010) select the boundary chain with `bsr_test_mode`=1. SAMPLE (00000001) selects the boundary chain with `bsr_test_mode`=0. IDCODE (11111110) selects the 32-bit identification word. USERCODE (11111101) selects the 32-bit user word. BYPASS (11111111) selects the one-bit stage.
- R8: Any 8-bit value not listed in R6 or R7 decodes as BYPASS.
- R9: Capture-DR loads 0 into the one-bit stage. While it is selected, `tdo` repeats `tdi` one shift later.
- R10: `tdo` and `tdo_en` change only on falling `tck` edges. `tdo_en` is 1 only in Shift-IR and Shift-DR.
- R11: In Pause-DR the selected data register keeps its content while `tdi` toggles. Returning through Exit2-DR to Shift-DR resumes the stream at the next bit.
- R12: `bsr_capture`, `bsr_shift` and `bsr_update` are high only in Capture-DR, Shift-DR and Update-DR respectively, and only while the boundary chain is selected. While the chain is being shifted, `tdo` carries `bsr_so`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on clear, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo` |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| bsr_capture | output | 1 | Boundary chain parallel-capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_test_mode | output | 1 | Boundary cells drive the pins |
| pins_disable | output | 1 | Floats every functional output |

## Verification
The hardest case to reach is a change of the current instruction at a moment other than Update-IR. The bench builds it by parking the port in HIGHZ and then shifting a different opcode all the way through Shift-IR and into Pause-IR. It checks the disable output at each of these points, and only then lets Update-IR take effect. A second hard case is the five-edge reset from deep inside the DR column. The bench enters Shift-DR with HIGHZ current, checks that four high `tms` edges leave the disable set, and checks that the fifth clears it.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 8;

  typedef enum logic [3:0] {
    ST_RESET   = 4'd0,
    ST_IDLE    = 4'd1,
    ST_SEL_DR  = 4'd2,
    ST_CAP_DR  = 4'd3,
    ST_SH_DR   = 4'd4,
    ST_EX1_DR  = 4'd5,
    ST_PAU_DR  = 4'd6,
    ST_EX2_DR  = 4'd7,
    ST_UPD_DR  = 4'd8,
    ST_SEL_IR  = 4'd9,
    ST_CAP_IR  = 4'd10,
    ST_SH_IR   = 4'd11,
    ST_EX1_IR  = 4'd12,
    ST_PAU_IR  = 4'd13,
    ST_EX2_IR  = 4'd14,
    ST_UPD_IR  = 4'd15
  } tap_state_e;

  typedef enum logic [1:0] {
    DSEL_BYP  = 2'd0,
    DSEL_ID   = 2'd1,
    DSEL_USER = 2'd2,
    DSEL_BND  = 2'd3
  } dsel_e;

  typedef struct packed {
    dsel_e sel;
    logic  test_mode;
    logic  hiz;
  } ir_dec_t;

  localparam logic [IR_W-1:0] OP_EXTEST   = 8'b0000_0000;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 8'b0000_0001;
  localparam logic [IR_W-1:0] OP_INTEST   = 8'b0000_0010;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 8'b1111_1100;
  localparam logic [IR_W-1:0] OP_USERCODE = 8'b1111_1101;
  localparam logic [IR_W-1:0] OP_IDCODE   = 8'b1111_1110;
  localparam logic [IR_W-1:0] OP_BYPASS   = 8'b1111_1111;

  // Capture pattern: fixed 01 in the two low bits, free bits taken as 0.
  localparam logic [IR_W-1:0] IR_CAPTURE  = 8'b0000_0001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction

  function automatic ir_dec_t ir_decode(input logic [IR_W-1:0] op);
    ir_dec_t d;
    d = '{sel: DSEL_BYP, test_mode: 1'b0, hiz: 1'b0};
    case (op)
      OP_EXTEST, OP_INTEST: begin d.sel = DSEL_BND; d.test_mode = 1'b1; end
      OP_SAMPLE:            d.sel = DSEL_BND;
      OP_IDCODE:            d.sel = DSEL_ID;
      OP_USERCODE:          d.sel = DSEL_USER;
      OP_HIGHZ:             d.hiz = 1'b1;
      default:              d.sel = DSEL_BYP;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e st
);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) st <= ST_RESET;
    else        st <= tap_next(st, tms);
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  tap_state_e      st,
  input  logic            tdi,
  output logic            ir_so,
  output logic [IR_W-1:0] ir_cur,
  output ir_dec_t         dec
);

  logic [IR_W-1:0] ir_sr;

  // Shift stage: rising edge, capture or shift toward the LSB.
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                 ir_sr <= IR_CAPTURE;
    else if (st == ST_CAP_IR)   ir_sr <= IR_CAPTURE;
    else if (st == ST_SH_IR)    ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  // Current instruction: falling edge, only in Update-IR or reset state.
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n)                 ir_cur <= OP_IDCODE;
    else if (st == ST_RESET)    ir_cur <= OP_IDCODE;
    else if (st == ST_UPD_IR)   ir_cur <= ir_sr;
  end

  assign ir_so = ir_sr[0];
  assign dec   = ir_decode(ir_cur);

endmodule

// File: rtl/tap_shreg.sv
module tap_shreg #(
  parameter int           W   = 32,
  parameter logic [W-1:0] CAP = '0
) (
  input  logic tck,
  input  logic por_n,
  input  logic cap_en,
  input  logic sh_en,
  input  logic si,
  output logic so
);

  logic [W-1:0] q;

  generate
    if (W == 1) begin : g_bit
      always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)      q <= CAP;
        else if (cap_en) q <= CAP;
        else if (sh_en)  q <= si;
      end
    end else begin : g_vec
      always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)      q <= CAP;
        else if (cap_en) q <= CAP;
        else if (sh_en)  q <= {si, q[W-1:1]};
      end
    end
  endgenerate

  assign so = q[0];

endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter int            ID_W       = 32,
  parameter logic [ID_W-1:0] ID_VALUE   = 32'h1A5C_E0B3,
  parameter logic [ID_W-1:0] USER_VALUE = 32'h0000_C0DE
) (
  input  logic tck,
  input  logic por_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_en,
  input  logic bsr_so,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic bsr_test_mode,
  output logic pins_disable
);

  localparam int NREG = 3;  // internal data registers: bypass, id, user

  tap_state_e      st;
  logic [IR_W-1:0] ir_cur;
  ir_dec_t         dec;
  logic            ir_so;
  dsel_e           dsel;
  logic            in_cap_dr, in_sh_dr, in_upd_dr, in_shift;
  logic [NREG-1:0] reg_so;
  logic            byp_q;
  logic            dr_so;

  tap_fsm u_fsm (
    .tck   (tck),
    .por_n (por_n),
    .tms   (tms),
    .st    (st)
  );

  tap_ir u_ir (
    .tck    (tck),
    .por_n  (por_n),
    .st     (st),
    .tdi    (tdi),
    .ir_so  (ir_so),
    .ir_cur (ir_cur),
    .dec    (dec)
  );

  assign dsel      = dec.sel;
  assign in_cap_dr = (st == ST_CAP_DR);
  assign in_sh_dr  = (st == ST_SH_DR);
  assign in_upd_dr = (st == ST_UPD_DR);
  assign in_shift  = (st == ST_SH_DR) || (st == ST_SH_IR);

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_dr
      localparam int           RW  = (g == 0) ? 1 : ID_W;
      localparam logic [RW-1:0] RC = (g == 0) ? '0 :
                                     (g == 1) ? RW'(ID_VALUE) : RW'(USER_VALUE);
      logic hit;
      assign hit = (dsel == dsel_e'(g));
      tap_shreg #(.W(RW), .CAP(RC)) u_reg (
        .tck    (tck),
        .por_n  (por_n),
        .cap_en (in_cap_dr && hit),
        .sh_en  (in_sh_dr && hit),
        .si     (tdi),
        .so     (reg_so[g])
      );
    end
  endgenerate

  assign byp_q = reg_so[0];

  always_comb begin
    case (dsel)
      DSEL_BYP:  dr_so = reg_so[0];
      DSEL_ID:   dr_so = reg_so[1];
      DSEL_USER: dr_so = reg_so[2];
      default:   dr_so = bsr_so;
    endcase
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= in_shift;
      if (st == ST_SH_IR)      tdo <= ir_so;
      else if (st == ST_SH_DR) tdo <= dr_so;
    end
  end

  assign bsr_capture   = in_cap_dr && (dsel == DSEL_BND);
  assign bsr_shift     = in_sh_dr  && (dsel == DSEL_BND);
  assign bsr_update    = in_upd_dr && (dsel == DSEL_BND);
  assign bsr_test_mode = dec.test_mode;
  assign pins_disable  = dec.hiz;

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
  import tap_pkg::*;
(
  input logic            tck,
  input logic            por_n,
  input logic            tms,
  input tap_state_e      st,
  input logic [IR_W-1:0] ir_cur,
  input dsel_e           dsel,
  input logic            byp_q,
  input logic            tdo_en,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update,
  input logic            pins_disable
);

  logic [2:0] ones;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)           ones <= 3'd0;
    else if (!tms)        ones <= 3'd0;
    else if (ones < 3'd5) ones <= ones + 3'd1;
  end

  // R2: five high mode-select edges end in the reset state
  a_r2_tms_reset: assert property (@(posedge tck) disable iff (!por_n)
    (ones >= 3'd5) |-> (st == ST_RESET));

  // R5: current instruction moves only in Update-IR or the reset state
  a_r5_ir_update_only: assert property (@(posedge tck) disable iff (!por_n)
    !$stable(ir_cur) |-> (st == ST_UPD_IR || st == ST_RESET));

  // R6: output disable always goes with the bypass path
  a_r6_hiz_bypass: assert property (@(posedge tck) disable iff (!por_n)
    pins_disable |-> (dsel == DSEL_BYP));

  // R9: bypass bit holds 0 right after Capture-DR
  a_r9_bypass_zero: assert property (@(posedge tck) disable iff (!por_n)
    (st == ST_CAP_DR && dsel == DSEL_BYP) |=> !byp_q);

  // R10: output enable only in the two shift states
  a_r10_tdo_en_shift: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en |-> (st == ST_SH_DR || st == ST_SH_IR));

  // R12: boundary strobes are mutually exclusive
  a_r12_strobe_excl: assert property (@(posedge tck) disable iff (!por_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

  // R3: reset state leaves outputs enabled
  a_r3_reset_clear: assert property (@(posedge tck) disable iff (!por_n)
    (st == ST_RESET) |=> !pins_disable);

endmodule

bind tap_port tap_port_chk u_chk (
  .tck          (tck),
  .por_n        (por_n),
  .tms          (tms),
  .st           (st),
  .ir_cur       (ir_cur),
  .dsel         (dsel),
  .byp_q        (byp_q),
  .tdo_en       (tdo_en),
  .bsr_capture  (bsr_capture),
  .bsr_shift    (bsr_shift),
  .bsr_update   (bsr_update),
  .pins_disable (pins_disable)
);

// File: tb/tap_port_bench.sv
module tap_port_bench;

  localparam int          CYC  = 10;
  localparam logic [31:0] IDV  = 32'h1A5C_E0B3;
  localparam logic [31:0] USRV = 32'h0000_C0DE;

  // {opcode[7:0], kind[1:0] (0 bypass,1 id,2 user,3 boundary), test_mode, hiz}
  localparam logic [11:0] VEC [8] = '{
    {8'hFF, 2'd0, 1'b0, 1'b0},
    {8'h00, 2'd3, 1'b1, 1'b0},
    {8'hFE, 2'd1, 1'b0, 1'b0},
    {8'h02, 2'd3, 1'b1, 1'b0},
    {8'h01, 2'd3, 1'b0, 1'b0},
    {8'hFD, 2'd2, 1'b0, 1'b0},
    {8'hFC, 2'd0, 1'b0, 1'b1},
    {8'h5A, 2'd0, 1'b0, 1'b0}
  };

  logic tck = 1'b0;
  logic por_n, tms, tdi, bsr_so;
  logic tdo, tdo_en, bsr_capture, bsr_shift, bsr_update, bsr_test_mode, pins_disable;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic cap_seen, sh_seen, upd_seen, en_seen;

  always #(CYC/2) tck = ~tck;

  tap_port u_tap_port (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .bsr_so(bsr_so), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update), .bsr_test_mode(bsr_test_mode), .pins_disable(pins_disable)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck);
    @(negedge tck); #1;
  endtask

  // From Run-Test/Idle, load an opcode; return the captured IR bits.
  task automatic load_ir(input logic [7:0] op, output logic [7:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 8; i++) begin
      cap[i] = tdo;
      step(i == 7, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  // From Run-Test/Idle, shift n DR bits; records boundary strobes.
  task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    step(1, 0); step(0, 0);
    cap_seen = bsr_capture;
    step(0, 0);
    sh_seen = bsr_shift; en_seen = tdo_en;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0);
    upd_seen = bsr_update;
    step(0, 0);
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  cap;
    logic [31:0] dout, exp;
    por_n = 0; tms = 1; tdi = 0; bsr_so = 0;
    repeat (3) @(negedge tck);
    #1;
    // R3: reset state
    chk(pins_disable == 0, "R3 disable after power-on", pins_disable, 0);
    chk(tdo_en == 0, "R3 tdo_en after power-on", tdo_en, 0);
    chk(bsr_test_mode == 0, "R3 test mode after power-on", bsr_test_mode, 0);
    por_n = 1;
    step(1, 0);
    step(0, 0);
    chk(tdo_en == 0, "R10 tdo_en idle", tdo_en, 0);
    // R3: IDCODE current after power-on
    shift_dr(32, 32'h0, dout);
    chk(dout == IDV, "R3 default IDCODE", dout, IDV);

    // Table walk: R4 R6 R7 R8 R9 R12
    for (int v = 0; v < 8; v++) begin
      logic [7:0] op;
      logic [1:0] kind;
      op = VEC[v][11:4]; kind = VEC[v][3:2];
      load_ir(op, cap);
      chk(cap == 8'h01, "R4 capture pattern", cap, 8'h01);
      chk(bsr_test_mode == VEC[v][1], "R7 test mode decode", {op, 7'd0, bsr_test_mode}, {op, 7'd0, VEC[v][1]});
      chk(pins_disable == VEC[v][0], "R6 disable decode", {op, 7'd0, pins_disable}, {op, 7'd0, VEC[v][0]});
      case (kind)
        2'd0: begin
          shift_dr(8, 32'hA5, dout);
          exp = {24'd0, 8'hA5 << 1};
          chk(dout == exp, "R8 R9 bypass path", dout, exp);
        end
        2'd1: begin
          shift_dr(32, 32'h0, dout);
          chk(dout == IDV, "R7 id word", dout, IDV);
        end
        2'd2: begin
          shift_dr(32, 32'h0, dout);
          chk(dout == USRV, "R7 user word", dout, USRV);
        end
        default: begin
          bsr_so = 1;
          shift_dr(4, 32'h0, dout);
          bsr_so = 0;
          chk(dout[3:0] == 4'hF, "R12 boundary serial out", dout, 32'hF);
        end
      endcase
      chk({cap_seen, sh_seen, upd_seen} == {3{kind == 2'd3}}, "R12 boundary strobes",
          {cap_seen, sh_seen, upd_seen}, {3{kind == 2'd3}});
      chk(en_seen == 1, "R10 tdo_en in shift", en_seen, 1);
    end

    // R10: tdo moves on the falling edge only (BYPASS loaded here)
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    chk(tdo == 1, "R4 first captured bit", tdo, 1);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk(tdo == 1, "R10 tdo held at rising edge", tdo, 1);
    @(negedge tck); #1;
    chk(tdo == 0, "R10 tdo after falling edge", tdo, 0);
    for (int i = 1; i < 8; i++) step(i == 7, 1);
    step(1, 0); step(0, 0);

    // R5: shifting and pausing in the IR column keep the instruction
    load_ir(8'hFC, cap);
    chk(pins_disable == 1, "R6 HIGHZ loaded", pins_disable, 1);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 8; i++) step(i == 7, 1'b0);
    chk(pins_disable == 1, "R5 held in Exit1-IR", pins_disable, 1);
    step(0, 0);
    chk(pins_disable == 1, "R5 held in Pause-IR", pins_disable, 1);
    chk(tdo_en == 0, "R10 tdo_en in pause", tdo_en, 0);
    step(1, 0);
    chk(pins_disable == 1, "R5 held in Exit2-IR", pins_disable, 1);
    step(1, 0);
    chk(pins_disable == 0 && bsr_test_mode == 1, "R5 applied at Update-IR",
        {pins_disable, bsr_test_mode}, 2'b01);
    step(0, 0);

    // R11: pause in the DR column with IDCODE selected
    load_ir(8'hFE, cap);
    step(1, 0); step(0, 0); step(0, 0);
    dout = '0;
    for (int i = 0; i < 32; i++) begin
      dout[i] = tdo;
      if (i == 9) begin
        step(1, 0); step(0, 1); step(0, 0); step(0, 1);
        chk(tdo_en == 0, "R11 no output in Pause-DR", tdo_en, 0);
        step(1, 0); step(0, 0);
      end else begin
        step(i == 31, 0);
      end
    end
    step(1, 0); step(0, 0);
    chk(dout == IDV, "R11 stream resumes after pause", dout, IDV);

    // R2: four highs from Shift-DR keep HIGHZ, the fifth resets
    load_ir(8'hFC, cap);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(1, 0);
    chk(pins_disable == 1, "R2 four highs not enough", pins_disable, 1);
    step(1, 0);
    chk(pins_disable == 0, "R2 R3 fifth high resets", pins_disable, 0);
    step(0, 0);
    shift_dr(32, 32'h0, dout);
    chk(dout == IDV, "R1 R3 IDCODE after TMS reset", dout, IDV);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule